// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block watches eleven level-sensitive interrupt lines coming from a bus bridge. It tells a host processor about activity on them by posting a single memory write. The data word and target address of that write are programmed by software. Each line is brought into the clock domain, and any change of level, rising or falling, is recorded. A change on a line that software has unmasked latches a request bit and launches one message on a valid/ready write port.

Software sees five word registers on a simple access port:
- a message register holding an aligned target address with a small data value in its low bits;
- a request register that clears when read;
- a pending register that records changes on every line, masked or not, and also clears when read;
- the mask register;
- a live-level view of the synchronised lines.

The live view lets software emulate level triggering. If a line is still asserted after service, software can issue a replay write that sends the message again.

Only one message is ever outstanding. Changes that arrive while it waits are folded into the request register and do not create a second write.

Top module: `irq_msg_agg`

## Requirements
- R1: After reset the mask, request, pending and message registers read 0 and `msg_valid` is low.
- R2: Line state, pending and request bits are qualified by the implemented-line mask 0x5FF (bits 0–8 and 10). Bit 9 always reads 0, and writing all ones to the mask reads back 0x5FF.
- R3: The live register (offset 0x028) shows each implemented line's level two clock edges after the pin changes. Reading it changes nothing.
- R4: A change in either direction on any implemented line sets its bit in the pending register (offset 0x01C), whether or not the line is masked. A read returns the bits and clears them. A change recorded in the same cycle as the read stays set.
- R5: A change on an unmasked line sets its bit in the request register (offset 0x00C). A read returns the bits and clears them, and a change in the same cycle stays set.
- R6: `msg_valid` rises on the same clock edge that latches the request bit for an unmasked change, three edges after the pin changes.
- R7: A line that is already asserted when it is unmasked raises no message and no request bit until it next changes.
- R8: While `msg_valid` is high and `msg_ready` low, the address and data hold steady. Further changes merge into that single message, so one handshake retires them all.
- R9: The message register (offset 0x004) is readable and writable. A message carries the register's value with its low DATA_W bits cleared as address, and those low bits as data, captured when the message is launched.
- R10: A host write to the request register offset launches a message (a replay) and leaves the request bits unchanged.
- R11: The mask register (offset 0x018) is readable and writable. A bit of 1 enables the line, and a new mask applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Interrupt lines, level sensitive |
| reg_en | input | 1 | Register access strobe, one word per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read access |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Message accepted when high with `msg_valid` |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
The bench builds the block with eleven lines, implemented mask 0x5FF, a five-bit data field, a two-stage synchroniser and twelve address bits. These values make the hole at bit 9 observable, as well as the split of the message word at bit 5 and the exact three-edge latency from pin to message. Directed passes cover unmasking a line that is already high, merging while the output is stalled, replay writes, and clear-on-read racing a new change. A randomised pass then mixes line toggles, register traffic and back-pressure.

// File: rtl/irq_msg_agg_pkg.sv
package irq_msg_agg_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned OFF_MSG  = 32'h004;
   localparam int unsigned OFF_REQ  = 32'h00C;
   localparam int unsigned OFF_MASK = 32'h018;
   localparam int unsigned OFF_PEND = 32'h01C;
   localparam int unsigned OFF_LIVE = 32'h028;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_MSG,
      SEL_REQ,
      SEL_MASK,
      SEL_PEND,
      SEL_LIVE
   } reg_sel_e;

endpackage

// File: rtl/irq_msg_agg_sync.sv
module irq_msg_agg_sync #(
   parameter int unsigned W      = 11,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] IMPL  = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lines,
   output logic [W-1:0] level,
   output logic [W-1:0] change
);

   logic [W-1:0] prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign level = lines & IMPL;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= lines & IMPL;
               for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign level = stage_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   assign change = level ^ prev_q;

endmodule

// File: rtl/irq_msg_agg_regs.sv
module irq_msg_agg_regs
   import irq_msg_agg_pkg::*;
#(
   parameter int unsigned NUM_IRQ        = 11,
   parameter logic [NUM_IRQ-1:0] IMPL    = '1,
   parameter int unsigned ADDR_W         = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_en,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [WORD_W-1:0]  reg_wdata,
   output logic [WORD_W-1:0]  reg_rdata,
   input  logic [NUM_IRQ-1:0] level,
   input  logic [NUM_IRQ-1:0] change,
   output logic [NUM_IRQ-1:0] mask_o,
   output logic [WORD_W-1:0]  cfg_o,
   output logic               replay_o
);

   reg_sel_e           sel;
   logic               rd_acc, wr_acc;
   logic [NUM_IRQ-1:0] mask_q, req_q, pend_q;
   logic [NUM_IRQ-1:0] evt, hit;
   logic [WORD_W-1:0]  cfg_q;

   always_comb begin
      if      (reg_addr == ADDR_W'(OFF_MSG))  sel = SEL_MSG;
      else if (reg_addr == ADDR_W'(OFF_REQ))  sel = SEL_REQ;
      else if (reg_addr == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
      else if (reg_addr == ADDR_W'(OFF_PEND)) sel = SEL_PEND;
      else if (reg_addr == ADDR_W'(OFF_LIVE)) sel = SEL_LIVE;
      else                                    sel = SEL_NONE;
   end

   assign rd_acc = reg_en & ~reg_we;
   assign wr_acc = reg_en &  reg_we;
   assign evt    = change & IMPL;
   assign hit    = evt & mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         req_q  <= '0;
         pend_q <= '0;
         cfg_q  <= '0;
      end else begin
         if (wr_acc && sel == SEL_MASK) mask_q <= reg_wdata[NUM_IRQ-1:0] & IMPL;
         if (wr_acc && sel == SEL_MSG)  cfg_q  <= reg_wdata;
         req_q  <= ((rd_acc && sel == SEL_REQ)  ? '0 : req_q)  | hit;
         pend_q <= ((rd_acc && sel == SEL_PEND) ? '0 : pend_q) | evt;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (rd_acc) begin
         unique case (sel)
            SEL_MSG:  reg_rdata = cfg_q;
            SEL_REQ:  reg_rdata = WORD_W'(req_q);
            SEL_MASK: reg_rdata = WORD_W'(mask_q);
            SEL_PEND: reg_rdata = WORD_W'(pend_q);
            SEL_LIVE: reg_rdata = WORD_W'(level);
            default:  reg_rdata = '0;
         endcase
      end
   end

   assign mask_o   = mask_q;
   assign cfg_o    = cfg_q;
   assign replay_o = wr_acc && sel == SEL_REQ;

   // R4: every recorded change is visible in pending after the edge
   p_pend_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((pend_q & $past(evt)) == $past(evt)));

   // R5: an unmasked change always lands in the request register
   p_req_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((req_q & $past(hit)) == $past(hit)));

endmodule

// File: rtl/irq_msg_agg_msg.sv
module irq_msg_agg_msg #(
   parameter int unsigned NUM_IRQ = 11,
   parameter int unsigned DATA_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] change,
   input  logic [NUM_IRQ-1:0] mask,
   input  logic               replay,
   input  logic [31:0]        cfg,
   input  logic               msg_ready,
   output logic               msg_valid,
   output logic [31:0]        msg_addr,
   output logic [31:0]        msg_data
);

   logic fire, launch;

   assign fire   = (|(change & mask)) | replay;
   assign launch = fire & (~msg_valid | msg_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else begin
         msg_valid <= launch | (msg_valid & ~msg_ready);
         if (launch) begin
            msg_addr <= {cfg[31:DATA_W], {DATA_W{1'b0}}};
            msg_data <= {{(32-DATA_W){1'b0}}, cfg[DATA_W-1:0]};
         end
      end
   end

   // R6: an unmasked change is followed by a valid message
   p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(change & mask)) |=> msg_valid);

   // R8: a stalled message keeps its contents
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

   // R7: nothing to report means no new message
   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!msg_valid && !(|(change & mask)) && !replay) |=> !msg_valid);

endmodule

// File: rtl/irq_msg_agg.sv
module irq_msg_agg
   import irq_msg_agg_pkg::*;
#(
   parameter int unsigned NUM_IRQ          = 11,
   parameter logic [NUM_IRQ-1:0] IMPL_MASK = 11'h5FF,
   parameter int unsigned DATA_W           = 5,
   parameter int unsigned SYNC_STAGES      = 2,
   parameter int unsigned ADDR_W           = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_in,
   input  logic               reg_en,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [31:0]        msg_addr,
   output logic [31:0]        msg_data
);

   generate
      if (NUM_IRQ < 1 || NUM_IRQ > WORD_W) begin : g_bad_irq
         $error("NUM_IRQ must lie in 1..32");
      end
      if (DATA_W < 1 || DATA_W > 16) begin : g_bad_data
         $error("DATA_W must lie in 1..16");
      end
      if (ADDR_W < 6 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 6..16");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [NUM_IRQ-1:0] level, change, mask;
   logic [31:0]        cfg;
   logic               replay;

   irq_msg_agg_sync #(
      .W      (NUM_IRQ),
      .STAGES (SYNC_STAGES),
      .IMPL   (IMPL_MASK)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .lines  (irq_in),
      .level  (level),
      .change (change)
   );

   irq_msg_agg_regs #(
      .NUM_IRQ (NUM_IRQ),
      .IMPL    (IMPL_MASK),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_en    (reg_en),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .level     (level),
      .change    (change),
      .mask_o    (mask),
      .cfg_o     (cfg),
      .replay_o  (replay)
   );

   irq_msg_agg_msg #(
      .NUM_IRQ (NUM_IRQ),
      .DATA_W  (DATA_W)
   ) u_msg (
      .clk       (clk),
      .rst_n     (rst_n),
      .change    (change),
      .mask      (mask),
      .replay    (replay),
      .cfg       (cfg),
      .msg_ready (msg_ready),
      .msg_valid (msg_valid),
      .msg_addr  (msg_addr),
      .msg_data  (msg_data)
   );

endmodule

// File: tb/irq_msg_agg_tb.sv
module irq_msg_agg_tb;

   localparam int NIRQ = 11;
   localparam logic [10:0] IMPL = 11'h5FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] irq_in = '0;
   logic        reg_en = 1'b0, reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        msg_valid, msg_ready = 1'b0;
   logic [31:0] msg_addr, msg_data;

   int total = 0, bad = 0, accepts = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   irq_msg_agg #(
      .NUM_IRQ (NIRQ), .IMPL_MASK (IMPL), .DATA_W (5), .SYNC_STAGES (2), .ADDR_W (12)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .irq_in (irq_in),
      .reg_en (reg_en), .reg_we (reg_we), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .msg_valid (msg_valid), .msg_ready (msg_ready),
      .msg_addr (msg_addr), .msg_data (msg_data)
   );

   // behavioural reference
   logic [10:0] m_s1, m_lvl, m_prv, m_mask, m_req, m_pend;
   logic [31:0] m_cfg, m_ma, m_md;
   logic        m_v;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 0; m_lvl = 0; m_prv = 0; m_mask = 0; m_req = 0; m_pend = 0;
         m_cfg = 0; m_ma = 0; m_md = 0; m_v = 0;
      end else begin
         logic [10:0] ch;
         logic rd, wr, fire;
         ch   = m_lvl ^ m_prv;
         rd   = reg_en && !reg_we;
         wr   = reg_en && reg_we;
         fire = ((ch & m_mask) != 0) || (wr && reg_addr == 12'h00C);
         if (fire && (!m_v || msg_ready)) begin
            m_v = 1; m_ma = m_cfg & 32'hFFFF_FFE0; m_md = m_cfg & 32'h1F;
         end else if (m_v && msg_ready) m_v = 0;
         m_req  = ((rd && reg_addr == 12'h00C) ? 11'h0 : m_req) | (ch & m_mask);
         m_pend = ((rd && reg_addr == 12'h01C) ? 11'h0 : m_pend) | ch;
         if (wr && reg_addr == 12'h018) m_mask = reg_wdata[10:0] & IMPL;
         if (wr && reg_addr == 12'h004) m_cfg = reg_wdata;
         m_prv = m_lvl; m_lvl = m_s1; m_s1 = irq_in & IMPL;
      end
   end

   function automatic logic [31:0] model_rd();
      if (!(reg_en && !reg_we)) return 0;
      case (reg_addr)
         12'h004: return m_cfg;
         12'h00C: return 32'(m_req);
         12'h018: return 32'(m_mask);
         12'h01C: return 32'(m_pend);
         12'h028: return 32'(m_lvl);
         default: return 0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string rd_tag(input logic [11:0] a);
      case (a)
         12'h004: return "R9 message reg";
         12'h00C: return "R5 request reg";
         12'h018: return "R11 mask reg";
         12'h01C: return "R4 pending reg";
         12'h028: return "R3 live reg";
         default: return "R1 unmapped read";
      endcase
   endfunction

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (!done) begin
         chk("R6 msg_valid", 32'(msg_valid), 32'(m_v));
         if (m_v) begin
            chk("R9 msg_addr", msg_addr, m_ma);
            chk("R9 msg_data", msg_data, m_md);
         end
         chk(rd_tag(reg_addr), reg_rdata, model_rd());
         if (msg_valid && msg_ready) accepts++;
      end
   end

   task automatic step(); @(posedge clk); #2; endtask
   task automatic idle(input int n); repeat (n) step(); endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      step(); reg_en = 1; reg_we = 0; reg_addr = a;
      @(negedge clk); v = reg_rdata;
      step(); reg_en = 0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      step(); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
      step(); reg_en = 0; reg_we = 0;
   endtask

   task automatic set_lines(input logic [10:0] v);
      step(); irq_in = v;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int a0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset state
      rd(12'h00C, v); chk("R1 request after reset", v, 0);
      rd(12'h018, v); chk("R1 mask after reset", v, 0);
      rd(12'h01C, v); chk("R1 pending after reset", v, 0);
      rd(12'h004, v); chk("R1 message reg after reset", v, 0);
      chk("R1 msg_valid after reset", 32'(msg_valid), 0);

      // R9 message register
      wr(12'h004, 32'h8000_0013);
      rd(12'h004, v); chk("R9 message reg readback", v, 32'h8000_0013);

      // R11 and R2 mask width
      wr(12'h018, 32'hFFFF_FFFF);
      rd(12'h018, v); chk("R2 mask implemented bits", v, 32'h5FF);
      wr(12'h018, 32'h0);
      rd(12'h018, v); chk("R11 mask cleared", v, 0);

      // R4 pending records masked lines, clears on read
      set_lines(11'h004); idle(4);
      rd(12'h01C, v); chk("R4 pending masked change", v, 32'h4);
      rd(12'h01C, v); chk("R4 pending cleared by read", v, 0);
      rd(12'h028, v); chk("R3 live level", v, 32'h4);
      chk("R6 no message while masked", 32'(msg_valid), 0);

      // R7 unmasking an asserted line
      wr(12'h018, 32'h5); idle(4);
      chk("R7 no message on unmask", 32'(msg_valid), 0);
      rd(12'h00C, v); chk("R7 no request on unmask", v, 0);

      // R6 / R8 / R5 message launch and merging
      msg_ready = 0; a0 = accepts;
      set_lines(11'h005); idle(4);
      chk("R6 message raised", 32'(msg_valid), 1);
      chk("R9 message address", msg_addr, 32'h8000_0000);
      chk("R9 message data", msg_data, 32'h13);
      set_lines(11'h004); idle(4);
      chk("R8 still one message", 32'(msg_valid), 1);
      step(); msg_ready = 1;
      step(); msg_ready = 0;
      idle(2);
      chk("R8 merged into one handshake", 32'(accepts - a0), 1);
      chk("R8 valid drops after accept", 32'(msg_valid), 0);
      rd(12'h00C, v); chk("R5 request bit latched", v, 32'h1);
      rd(12'h00C, v); chk("R5 request cleared by read", v, 0);

      // R10 replay
      wr(12'h00C, 32'h0);
      chk("R10 replay raises message", 32'(msg_valid), 1);
      rd(12'h00C, v); chk("R10 replay leaves request clear", v, 0);
      msg_ready = 1; idle(2);

      // R2 unimplemented bit, R3 read without side effect
      set_lines(11'h7FF); idle(4);
      rd(12'h028, v); chk("R2 live qualified by mask", v, 32'h5FF);
      rd(12'h028, v); chk("R3 live read repeatable", v, 32'h5FF);
      rd(12'h01C, v); chk("R2 pending hole at bit 9", v, 32'h5FB);
      idle(2);

      // randomised traffic, compared cycle by cycle
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] pick;
         step();
         if ($urandom_range(0, 3) == 0) irq_in = irq_in ^ (11'h1 << $urandom_range(0, 10));
         msg_ready = ($urandom_range(0, 2) != 0);
         reg_en    = ($urandom_range(0, 2) == 0);
         reg_we    = ($urandom_range(0, 3) == 0);
         pick      = 3'($urandom_range(0, 5));
         case (pick)
            3'd0: reg_addr = 12'h004;
            3'd1: reg_addr = 12'h00C;
            3'd2: reg_addr = 12'h018;
            3'd3: reg_addr = 12'h01C;
            3'd4: reg_addr = 12'h028;
            default: reg_addr = 12'h030;
         endcase
         reg_wdata = $urandom;
      end
      step(); reg_en = 0; msg_ready = 1;
      idle(4);
      finish_run();
   end

endmodule